// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs read and write cycles on a shared 16-bit address/data bus. A local requester presents an access: address, direction, memory or IO space, and which bytes of the word take part. The sequencer then steps through the bus states T1, T2, T3, any wait states and T4. In T1 it drives the address and pulses the address latch enable, so external latches can capture the address on the falling edge of that pulse. From T2 on, the same wires carry the transfer data: the block drives them for a write, and releases them for a read so the addressed device can answer.

The device paces the cycle with its ready line. A low ready at the end of T3, or at the end of any wait state, adds another wait state. When a read completes, the data seen on the bus is captured and handed back in T4, together with a one-cycle completion flag. With no request pending, the bus rests in idle states. A new request can be accepted in T4, so cycles can run back to back with no idle state between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: The address strobe `ale_o` is high in T1 and only in T1, the first cycle after a request is accepted. During T1 `ad_oe_o` is high and `ad_o` carries `{req_addr_i[15:1], A0}`.
- R2: The byte select is derived from `req_be_i` (bit 0 = low byte, bit 1 = high byte). `bhe_n_o` = 0 when the high byte is used. A0 = 1 only for a high-byte-only access. 2'b11 gives `bhe_n_o`=0 with A0=0. 2'b00 is treated as a low-byte access, so `bhe_n_o`=1 and A0=0. `bhe_n_o`=1 with A0=1 never appears. `bhe_n_o` holds its value from T1 through T4.
- R3: `mio_o` equals the request's memory flag (1 = memory, 0 = IO) and stays constant from T1 through T4. It is 0 in idle.
- R4: For a read, `ad_oe_o` is low from T2 through T4. `rd_n_o` is low in T2, T3 and every wait state, and high in T4.
- R5: For a write, `ad_o` carries `req_wdata_i` with `ad_oe_o` high from T2 through T4. `wr_n_o` is low in T2, T3 and every wait state, and high in T4. `rd_n_o` and `wr_n_o` are never low together.
- R6: If `ready_i` is low at the clock edge that ends T3 or a wait state, another wait state follows. A cycle with n low samples lasts n+4 clocks from T1 to T4 inclusive.
- R7: The value on `ad_i` at the edge where `ready_i` is sampled high is shown on `rdata_o`, with `done_o` high for exactly one cycle, in T4.
- R8: `req_ready_o` is high only in idle and in T4. A request with `req_valid_i` high in one of those states starts T1 on the next cycle. A request in T4 therefore skips the idle state.
- R9: With no request pending after T4, the bus goes idle with `ale_o`=0, `ad_oe_o`=0, `rd_n_o`=`wr_n_o`=`bhe_n_o`=1 and `mio_o`=0.
- R10: `rst_ni` low at any time forces the idle outputs of R9 at once, including in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory space, 0 = IO space |
| req_be_i | input | 2 | Byte lanes used (bit 0 low, bit 1 high) |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 16 | Write data |
| ready_i | input | 1 | Device ready |
| ad_i | input | 16 | Multiplexed bus, incoming value |
| ad_o | output | 16 | Multiplexed bus, driven value |
| ad_oe_o | output | 1 | Bus output enable |
| ale_o | output | 1 | Address latch enable |
| bhe_n_o | output | 1 | High byte enable, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| mio_o | output | 1 | 1 = memory access, 0 = IO access |
| done_o | output | 1 | Cycle completes (T4) |
| rdata_o | output | 16 | Captured read data |

## Verification
T1 outputs appear one clock after the edge that accepts a request. T2 and T3 follow on the next two clocks. T4 comes one clock after the first edge that samples `ready_i` high, so every wait requested by the bench moves `done_o` and the captured data back by exactly one clock. The bench drives and samples only on falling edges. For each vector it steps through the phases one clock at a time and compares the outputs it expects for the phase it has reached. `ready_i` is released at the phase that gives the requested number of wait states. Back-to-back acceptance and a reset in mid-cycle are checked at the exact cycle in which they must take effect.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;

  typedef struct packed {
    logic write;
    logic mem;
    logic bhe_n;
    logic a0;
  } cyc_attr_t;

  // high-byte-only is the sole case with A0 set; empty select falls back to low byte
  function automatic cyc_attr_t make_attr(logic write, logic mem, logic [1:0] be);
    cyc_attr_t a;
    a.write = write;
    a.mem   = mem;
    a.bhe_n = ~be[1];
    a.a0    = be[1] & ~be[0];
    return a;
  endfunction
endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       ready_i,
  output logic       accept_o,
  output logic       req_ready_o,
  output logic       capture_o,
  output bus_state_e state_o
);
  bus_state_e state_q, state_d;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_T4);
  assign accept_o    = req_ready_o && req_valid_i;
  assign capture_o   = ((state_q == ST_T3) || (state_q == ST_TW)) && ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = accept_o ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = accept_o ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bus_seq_hold.sv
module bus_seq_hold
  import bus_seq_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             capture_i,
  input  logic             write_i,
  input  logic             mem_i,
  input  logic [1:0]       be_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] ad_i,
  output cyc_attr_t        attr_o,
  output logic [BUS_W-1:0] addr_word_o,
  output logic [BUS_W-1:0] wdata_o,
  output logic [BUS_W-1:0] rdata_o
);
  cyc_attr_t        attr_q;
  logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q  <= '{write: 1'b0, mem: 1'b0, bhe_n: 1'b1, a0: 1'b0};
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      attr_q  <= make_attr(write_i, mem_i, be_i);
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= ad_i;
  end

  assign attr_o      = attr_q;
  assign addr_word_o = {addr_q[BUS_W-1:1], attr_q.a0};
  assign wdata_o     = wdata_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  bus_state_e       state_i,
  input  cyc_attr_t        attr_i,
  input  logic [BUS_W-1:0] addr_word_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             bhe_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             mio_o,
  output logic             done_o
);
  logic addr_ph, strobe_ph, data_ph, in_cyc;

  assign addr_ph   = (state_i == ST_T1);
  assign strobe_ph = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign data_ph   = strobe_ph || (state_i == ST_T4);
  assign in_cyc    = addr_ph || data_ph;

  always_comb begin
    if (addr_ph)                      ad_o = addr_word_i;
    else if (data_ph && attr_i.write) ad_o = wdata_i;
    else                              ad_o = '0;
  end

  assign ad_oe_o = addr_ph || (data_ph && attr_i.write);
  assign ale_o   = addr_ph;
  assign bhe_n_o = in_cyc ? attr_i.bhe_n : 1'b1;
  assign mio_o   = in_cyc && attr_i.mem;
  assign rd_n_o  = !(strobe_ph && !attr_i.write);
  assign wr_n_o  = !(strobe_ph && attr_i.write);
  assign done_o  = (state_i == ST_T4);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_mem_i,
  input  logic [1:0]       req_be_i,
  input  logic [BUS_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  input  logic             ready_i,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             bhe_n_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             mio_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rdata_o
);
  bus_state_e       state;
  cyc_attr_t        attr;
  logic             accept, capture;
  logic [BUS_W-1:0] addr_word, wdata;

  bus_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ready_i     (ready_i),
    .accept_o    (accept),
    .req_ready_o (req_ready_o),
    .capture_o   (capture),
    .state_o     (state)
  );

  bus_seq_hold #(.BUS_W(BUS_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .write_i     (req_write_i),
    .mem_i       (req_mem_i),
    .be_i        (req_be_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .ad_i        (ad_i),
    .attr_o      (attr),
    .addr_word_o (addr_word),
    .wdata_o     (wdata),
    .rdata_o     (rdata_o)
  );

  bus_seq_pins #(.BUS_W(BUS_W)) u_pins (
    .state_i     (state),
    .attr_i      (attr),
    .addr_word_i (addr_word),
    .wdata_i     (wdata),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .ale_o       (ale_o),
    .bhe_n_o     (bhe_n_o),
    .rd_n_o      (rd_n_o),
    .wr_n_o      (wr_n_o),
    .mio_o       (mio_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/bus_seq_checker.sv
module bus_seq_checker #(
  parameter int unsigned BUS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             ready_i,
  input logic [BUS_W-1:0] ad_o,
  input logic             ad_oe_o,
  input logic             ale_o,
  input logic             bhe_n_o,
  input logic             rd_n_o,
  input logic             wr_n_o,
  input logic             mio_o,
  input logic             done_o
);
  assert_ale_drives_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o);
  assert_ale_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  assert_no_bad_select_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !(bhe_n_o && ad_o[0]));
  assert_select_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> $stable(bhe_n_o));
  assert_space_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> $stable(mio_o));
  assert_read_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o);
  assert_write_driven_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_n_o |-> ad_oe_o);
  assert_strobes_exclusive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  assert_wait_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rd_n_o || !wr_n_o) && !ready_i) |=> (!done_o && (!rd_n_o || !wr_n_o)));
  assert_done_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_n_o && wr_n_o && !ale_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_accept_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ale_o);
  assert_busy_refuses_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o || ale_o) |-> !req_ready_o);
endmodule

bind bus_cycle_seq bus_seq_checker #(.BUS_W(BUS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .ready_i     (ready_i),
  .ad_o        (ad_o),
  .ad_oe_o     (ad_oe_o),
  .ale_o       (ale_o),
  .bhe_n_o     (bhe_n_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .mio_o       (mio_o),
  .done_o      (done_o)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int unsigned W = 16;
  localparam int unsigned NVEC = 6;
  localparam int unsigned WATCHDOG = 20000;

  // {write, mem, be[1:0], waits[3:0], addr, wdata, rdata}
  localparam logic [55:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 2'b11, 4'd0, 16'h1234, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 2'b01, 4'd2, 16'h00F1, 16'h00A5, 16'h0000},
    {1'b0, 1'b0, 2'b10, 4'd1, 16'h8003, 16'h0000, 16'h5A00},
    {1'b1, 1'b1, 2'b11, 4'd3, 16'hFFFE, 16'h1357, 16'h0000},
    {1'b0, 1'b1, 2'b00, 4'd0, 16'h4445, 16'h0000, 16'h0F0F},
    {1'b1, 1'b1, 2'b10, 4'd0, 16'h2222, 16'hC300, 16'h0000}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic [1:0]   req_be = 2'b00;
  logic [W-1:0] req_addr = '0, req_wdata = '0, ad_in = '0;
  logic         ready = 1'b1;
  logic         req_ready, ad_oe, ale, bhe_n, rd_n, wr_n, mio, done;
  logic [W-1:0] ad_out, rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bus_cycle_seq #(.BUS_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_mem_i(req_mem), .req_be_i(req_be),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ready_i(ready), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ale_o(ale), .bhe_n_o(bhe_n), .rd_n_o(rd_n), .wr_n_o(wr_n),
    .mio_o(mio), .done_o(done), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // R2 select encoding, from the requirement text
  function automatic logic exp_bhe_n(input logic [1:0] be);
    return (be == 2'b10 || be == 2'b11) ? 1'b0 : 1'b1;
  endfunction
  function automatic logic exp_a0(input logic [1:0] be);
    return (be == 2'b10) ? 1'b1 : 1'b0;
  endfunction

  task automatic present(input logic w, input logic m, input logic [1:0] be,
                         input logic [W-1:0] a, input logic [W-1:0] d);
    req_valid = 1'b1; req_write = w; req_mem = m; req_be = be;
    req_addr = a; req_wdata = d;
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " R9 ale"}, ale, 1'b0);
    chk({tag, " R9 oe"}, ad_oe, 1'b0);
    chk({tag, " R9 rd_n"}, rd_n, 1'b1);
    chk({tag, " R9 wr_n"}, wr_n, 1'b1);
    chk({tag, " R9 bhe_n"}, bhe_n, 1'b1);
    chk({tag, " R9 mio"}, mio, 1'b0);
    chk({tag, " R8 ready"}, req_ready, 1'b1);
  endtask

  task automatic run_vec(input logic [55:0] v);
    logic w, m;
    logic [1:0] be;
    int nw;
    logic [W-1:0] a, wd, rd;
    w = v[55]; m = v[54]; be = v[53:52]; nw = int'(v[51:48]);
    a = v[47:32]; wd = v[31:16]; rd = v[15:0];
    @(negedge clk);
    present(w, m, be, a, wd);
    ad_in = rd;
    @(negedge clk);                       // T1
    req_valid = 1'b0;
    ready = (nw == 0);
    chk("R1 ale in T1", ale, 1'b1);
    chk("R1 oe in T1", ad_oe, 1'b1);
    chk("R1 address", ad_out, {a[W-1:1], exp_a0(be)});
    chk("R2 bhe_n", bhe_n, exp_bhe_n(be));
    chk("R3 mio", mio, m);
    chk("R8 busy in T1", req_ready, 1'b0);
    for (int ph = 0; ph < 2; ph++) begin  // T2, T3
      @(negedge clk);
      chk("R1 ale off", ale, 1'b0);
      chk("R4 rd_n", rd_n, w);
      chk("R5 wr_n", wr_n, !w);
      chk("R4 R5 oe", ad_oe, w);
      if (w) chk("R5 wdata", ad_out, wd);
      chk("R3 mio held", mio, m);
      chk("R2 bhe_n held", bhe_n, exp_bhe_n(be));
    end
    for (int k = 1; k <= nw; k++) begin   // Tw
      @(negedge clk);
      ready = (k == nw);
      chk("R6 wait no done", done, 1'b0);
      chk("R6 strobe held", w ? wr_n : rd_n, 1'b0);
    end
    @(negedge clk);                       // T4
    chk("R6 done after waits", done, 1'b1);
    if (!w) chk("R7 rdata", rdata, rd);
    chk("R4 rd_n T4", rd_n, 1'b1);
    chk("R5 wr_n T4", wr_n, 1'b1);
    chk("R4 R5 oe T4", ad_oe, w);
    if (w) chk("R5 wdata T4", ad_out, wd);
    chk("R3 mio T4", mio, m);
    chk("R8 ready T4", req_ready, 1'b1);
    @(negedge clk);                       // idle
    chk("R7 done pulse", done, 1'b0);
    check_idle("after vector");
    ready = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WATCHDOG);
        summary();
      end
    end
  end

  initial begin
    #1;
    check_idle("R10 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10 after reset");

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R8: back-to-back, request offered in T4 skips idle
    @(negedge clk);
    present(1'b0, 1'b1, 2'b11, 16'h0100, 16'h0000);
    ad_in = 16'h7777;
    ready = 1'b1;
    @(negedge clk);                       // T1
    req_valid = 1'b0;
    repeat (3) @(negedge clk);            // T2, T3, T4
    chk("R7 b2b done", done, 1'b1);
    chk("R7 b2b rdata", rdata, 16'h7777);
    present(1'b1, 1'b0, 2'b01, 16'h0202, 16'h4321);
    @(negedge clk);                       // straight to T1
    req_valid = 1'b0;
    chk("R8 b2b ale", ale, 1'b1);
    chk("R8 b2b address", ad_out, 16'h0202);
    chk("R3 b2b mio", mio, 1'b0);
    @(negedge clk);                       // T2
    chk("R5 b2b wdata", ad_out, 16'h4321);
    chk("R5 b2b wr_n", wr_n, 1'b0);

    // R10: reset in mid-cycle (now in T2 of a write)
    #1 rst_n = 1'b0;
    #1;
    chk("R10 mid reset wr_n", wr_n, 1'b1);
    chk("R10 mid reset oe", ad_oe, 1'b0);
    chk("R10 mid reset mio", mio, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10 released");
    chk("R10 no done", done, 1'b0);

    summary();
  end
endmodule